// File: doc/BRIEF.md
# Compressed Encoding Mode Tracker

This block follows the encoding mode of an instruction stream that mixes full 32-bit standard words with 16-bit compressed halfwords. Halfwords arrive in program order on a valid/ready input. For each complete instruction the tracker reports four things one cycle after acceptance: the form the instruction was decoded in (standard, short compressed or full compressed), its length in bytes, the running byte offset of the following instruction, and flags for illegal, immediate-format and misaligned instructions. It also exposes the mode that governs the next instruction.

The mode is not set by a page attribute or a global switch. Every compressed halfword carries its own mode-control bits. Those bits can keep the stream compressed, end compressed decoding, or drop to standard encoding for one word only, after which compressed decoding resumes without further help. The tracker reads only the top five bits, the compressed major/minor opcode and the two control bits. Everything else in an instruction is left to later stages.

Bit numbering in this note runs from 0 at the most significant end of a halfword, so bit 0 is `inHw[15]` and bit 15 is `inHw[0]`. Form codes are 0 standard, 1 short compressed and 2 full compressed. Mode codes are 0 strict standard, 1 full compressed and 2 one-shot standard.

Top module: `compressed_mode_tracker`

## Requirements
- R1: After reset, modeNow is 0 (strict standard), outValid is low and the next-instruction offset is 0.
- R2: In mode 0 or 2, a halfword whose bits 0 to 4 are not all zero starts a standard word. Nothing is reported for it. The next accepted halfword completes the word, which is reported as form 0 with length 4.
- R3: In mode 0 or 2, a halfword whose bits 0 to 4 are all zero is a short compressed instruction: form 1, length 2. Its bit 15 selects the next mode: 0 gives mode 0 and 1 gives mode 1.
- R4: In mode 1 each halfword is reported as form 2 with length 2. With bit 0 = 0, bit 15 = 1 keeps mode 1 and bit 15 = 0 gives mode 0.
- R5: In mode 1, bit 0 = 1 with bit 15 = 0 gives mode 2. The next standard word completed in mode 2 returns the tracker to mode 1.
- R6: In mode 1, bit 0 = 1 with bit 15 = 1 raises outImm and keeps mode 1. outImm is low for every other instruction.
- R7: In mode 1, when bits 5 to 8 equal 0011, bit 0 is ignored as a control bit. Bit 15 alone selects mode 1 (when 1) or mode 0 (when 0), and outImm stays low.
- R8: An all-zero halfword is flagged illegal in both compressed forms, and the next mode is 0. No other instruction is flagged illegal.
- R9: A halfword that is zero except bit 15 is a legal short nop and gives mode 1. In mode 1, a halfword that is zero except bit 0 is a legal nop and gives mode 2.
- R10: outNextOff is the byte offset of the next instruction. It advances by the reported length and wraps modulo 2^ADDR_W.
- R11: A standard word that starts at an offset with bit 1 set raises outMisalign in mode 0. It does not raise outMisalign in mode 2, and no other instruction raises it.
- R12: In mode 2, a halfword that decodes as short compressed drops the pending one-shot return. Its own bit 15 decides the next mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Halfword present on inHw |
| inReady | output | 1 | Tracker accepts a halfword (always high) |
| inHw | input | 16 | Instruction halfword, bit 0 of the stream at inHw[15] |
| outValid | output | 1 | One completed instruction is reported this cycle |
| outForm | output | 2 | Decoded form: 0 standard, 1 short compressed, 2 full compressed |
| outLen | output | 3 | Instruction length in bytes (2 or 4) |
| outNextOff | output | ADDR_W | Byte offset of the following instruction |
| outIllegal | output | 1 | Instruction is the all-zero illegal halfword |
| outImm | output | 1 | Full compressed halfword in immediate format |
| outMisalign | output | 1 | Standard word started off a 4-byte boundary in strict mode |
| modeNow | output | 2 | Mode for the next instruction: 0 strict, 1 compressed, 2 one-shot |

## Verification
A wrong mode register shows up on modeNow in the cycle after the halfword that should have set it. It also shows up on the next report, whose form and length then differ from the decode the stream calls for. A one-shot return that is never cleared, or that is lost, appears one word later as a standard form where a compressed one belongs, or the reverse. A wrong half-word pairing state shifts every later report, and outNextOff goes wrong on the next instruction that is reported. The bench keeps a reference of mode, pairing and offset, and it compares every report field and modeNow on each output cycle, so any divergence is caught at the first instruction it affects.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int HW_W = 16;

  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_C16 = 2'd1,
    MODE_ONE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    FORM_STD = 2'd0,
    FORM_C10 = 2'd1,
    FORM_C16 = 2'd2
  } form_e;

  // strobes from control to datapath, valid in the accepting cycle
  typedef struct packed {
    logic  emit;      // an instruction completes this cycle
    form_e form;
    logic  wide;      // 4-byte instruction
    logic  illegal;
    logic  immFmt;
    logic  alignChk;  // word completes in strict standard mode
  } strobe_t;

endpackage

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [HW_W-1:0] inHw,
  output strobe_t         strb,
  output mode_e           modeQ
);

  logic  midQ;
  logic  midD;
  mode_e modeD;

  // stream bit k sits at inHw[HW_W-1-k]
  logic       bitN;
  logic       bitM;
  logic       topZero;
  logic       subOp;
  logic       nEff;
  logic       allZero;

  assign bitN    = inHw[HW_W-1];
  assign bitM    = inHw[0];
  assign topZero = (inHw[HW_W-1:HW_W-5] == 5'd0);
  assign subOp   = (inHw[HW_W-6:HW_W-9] == 4'b0011);
  assign nEff    = bitN & ~subOp;
  assign allZero = (inHw == '0);

  always_comb begin
    strb  = '0;
    strb.form = FORM_STD;
    modeD = modeQ;
    midD  = midQ;
    if (inValid) begin
      if (midQ) begin
        strb.emit     = 1'b1;
        strb.form     = FORM_STD;
        strb.wide     = 1'b1;
        strb.alignChk = (modeQ == MODE_STD);
        midD          = 1'b0;
        modeD         = (modeQ == MODE_ONE) ? MODE_C16 : MODE_STD;
      end else if (modeQ == MODE_C16) begin
        strb.emit    = 1'b1;
        strb.form    = FORM_C16;
        strb.illegal = allZero;
        strb.immFmt  = nEff & bitM;
        if (bitM)      modeD = MODE_C16;
        else if (nEff) modeD = MODE_ONE;
        else           modeD = MODE_STD;
      end else if (topZero) begin
        strb.emit    = 1'b1;
        strb.form    = FORM_C10;
        strb.illegal = allZero;
        modeD        = bitM ? MODE_C16 : MODE_STD;
      end else begin
        midD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_STD;
      midQ  <= 1'b0;
    end else begin
      modeQ <= modeD;
      midQ  <= midD;
    end
  end

  // R8
  zero_to_std_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !midQ && inHw == '0) |=> (modeQ == MODE_STD));

  // R5
  oneshot_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && midQ && modeQ == MODE_ONE) |=> (modeQ == MODE_C16));

  // R7
  subop_no_oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !midQ && modeQ == MODE_C16 && inHw[HW_W-6:HW_W-9] == 4'b0011)
      |=> (modeQ != MODE_ONE));

  // R2
  word_pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !midQ && modeQ != MODE_C16 && inHw[HW_W-1:HW_W-5] != 5'd0)
      |=> $stable(modeQ));

endmodule

// File: rtl/cmt_dp.sv
module cmt_dp
  import cmt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              outValid,
  output logic [1:0]        outForm,
  output logic [2:0]        outLen,
  output logic [ADDR_W-1:0] outNextOff,
  output logic              outIllegal,
  output logic              outImm,
  output logic              outMisalign
);

  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrD;

  assign addrD = addrQ + (strb.wide ? STEP_WORD : STEP_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ       <= '0;
      outValid    <= 1'b0;
      outForm     <= FORM_STD;
      outLen      <= 3'd0;
      outIllegal  <= 1'b0;
      outImm      <= 1'b0;
      outMisalign <= 1'b0;
    end else begin
      outValid <= strb.emit;
      if (strb.emit) begin
        addrQ       <= addrD;
        outForm     <= strb.form;
        outLen      <= strb.wide ? 3'd4 : 3'd2;
        outIllegal  <= strb.illegal;
        outImm      <= strb.immFmt;
        outMisalign <= strb.alignChk & addrQ[1];
      end
    end
  end

  assign outNextOff = addrQ;

  // R10
  always_comb begin
    even_offset_chk: assert (!rstN || outNextOff[0] == 1'b0);
  end

  // R11
  misalign_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMisalign) |-> (outForm == FORM_STD && outLen == 3'd4));

  // R2
  word_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 3'd4) |-> (outForm == FORM_STD));

endmodule

// File: rtl/compressed_mode_tracker.sv
module compressed_mode_tracker
  import cmt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [15:0]       inHw,
  output logic              outValid,
  output logic [1:0]        outForm,
  output logic [2:0]        outLen,
  output logic [ADDR_W-1:0] outNextOff,
  output logic              outIllegal,
  output logic              outImm,
  output logic              outMisalign,
  output logic [1:0]        modeNow
);

  strobe_t strb;
  mode_e   modeQ;

  assign inReady = 1'b1;
  assign modeNow = modeQ;

  cmt_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inHw   (inHw),
    .strb   (strb),
    .modeQ  (modeQ)
  );

  cmt_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .outValid   (outValid),
    .outForm    (outForm),
    .outLen     (outLen),
    .outNextOff (outNextOff),
    .outIllegal (outIllegal),
    .outImm     (outImm),
    .outMisalign(outMisalign)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && modeNow == 2'd0 && outNextOff == '0));

endmodule

// File: tb/test_compressed_mode_tracker.sv
module test_compressed_mode_tracker;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid;
  logic          inReady;
  logic [15:0]   inHw;
  logic          outValid;
  logic [1:0]    outForm;
  logic [2:0]    outLen;
  logic [AW-1:0] outNextOff;
  logic          outIllegal;
  logic          outImm;
  logic          outMisalign;
  logic [1:0]    modeNow;

  always #5 clk = ~clk;

  compressed_mode_tracker #(.ADDR_W(AW)) i_compressed_mode_tracker (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inHw(inHw),
    .outValid(outValid), .outForm(outForm), .outLen(outLen),
    .outNextOff(outNextOff), .outIllegal(outIllegal), .outImm(outImm),
    .outMisalign(outMisalign), .modeNow(modeNow)
  );

  typedef struct {
    logic [1:0]    form;
    logic [2:0]    len;
    logic [AW-1:0] off;
    logic          ill;
    logic          imm;
    logic          mis;
    logic [1:0]    mode;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state: 0 strict, 1 compressed, 2 one-shot
  logic [1:0]    rMode;
  logic          rMid;
  logic [AW-1:0] rOff;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic refStep(input logic [15:0] h, input string tag);
    exp_t e;
    logic sub, n, m;
    e.tag = tag; e.ill = 1'b0; e.imm = 1'b0; e.mis = 1'b0;
    if (rMid) begin
      e.form = 2'd0; e.len = 3'd4;
      e.mis  = (rMode == 2'd0) && rOff[1];
      rMode  = (rMode == 2'd2) ? 2'd1 : 2'd0;
      rMid   = 1'b0;
      rOff   = rOff + AW'(4);
      e.off = rOff; e.mode = rMode;
      expQ.push_back(e);
    end else if (rMode == 2'd1) begin
      sub = (h[10:7] == 4'b0011);
      n = h[15] && !sub;
      m = h[0];
      e.form = 2'd2; e.len = 3'd2;
      e.ill = (h == 16'h0);
      e.imm = n && m;
      rMode = m ? 2'd1 : (n ? 2'd2 : 2'd0);
      rOff = rOff + AW'(2);
      e.off = rOff; e.mode = rMode;
      expQ.push_back(e);
    end else if (h[15:11] == 5'd0) begin
      e.form = 2'd1; e.len = 3'd2;
      e.ill = (h == 16'h0);
      rMode = h[0] ? 2'd1 : 2'd0;
      rOff = rOff + AW'(2);
      e.off = rOff; e.mode = rMode;
      expQ.push_back(e);
    end else begin
      rMid = 1'b1;
    end
  endtask

  task automatic sendHw(input logic [15:0] h, input string tag);
    @(negedge clk);
    inHw = h;
    inValid = 1'b1;
    refStep(h, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inHw = 16'hDEAD;
    end
  endtask

  // monitor: pops one expected item per reported instruction
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected report actual 1 expected 0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tag, "form", int'(outForm), int'(e.form));
        chk(e.tag, "len", int'(outLen), int'(e.len));
        chk("R10", "offset", int'(outNextOff), int'(e.off));
        chk(e.tag, "illegal", int'(outIllegal), int'(e.ill));
        chk(e.tag, "imm", int'(outImm), int'(e.imm));
        chk(e.tag, "misalign", int'(outMisalign), int'(e.mis));
        chk(e.tag, "mode", int'(modeNow), int'(e.mode));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inHw = 16'h0;
    rMode = 2'd0; rMid = 1'b0; rOff = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "outValid", int'(outValid), 0);
    chk("R1", "mode", int'(modeNow), 0);
    chk("R1", "offset", int'(outNextOff), 0);
    chk("R1", "inReady", int'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "mode after release", int'(modeNow), 0);

    sendHw(16'h7C00, "R2");   // word start, aligned
    chk("R2", "mode mid word", int'(modeNow), 0);
    sendHw(16'h0000, "R2");   // second half ignored as a control halfword
    sendHw(16'h0001, "R9");   // short nop -> compressed
    sendHw(16'h0101, "R4");   // N=0 M=1 stay
    sendHw(16'h8000, "R9");   // compressed nop -> one-shot
    sendHw(16'h4000, "R5");   // one-shot word at offset 10, no misalign
    sendHw(16'h1234, "R11");
    sendHw(16'h8101, "R6");   // immediate format
    sendHw(16'h8180, "R7");   // 001.1, N ignored, M=0 -> strict
    sendHw(16'hFFFF, "R11");  // strict word at offset 18 -> misalign
    sendHw(16'hFFFF, "R11");
    sendHw(16'h0000, "R8");   // short illegal
    idle(2);
    sendHw(16'h0003, "R3");   // short, M=1 -> compressed
    sendHw(16'h8181, "R7");   // 001.1, M=1 stays, no imm
    sendHw(16'h0000, "R8");   // compressed illegal -> strict
    sendHw(16'h0001, "R3");
    sendHw(16'h8002, "R5");   // N=1 M=0 -> one-shot
    sendHw(16'h0401, "R12");  // short in one-shot, M=1 -> compressed
    sendHw(16'h0100, "R4");   // N=0 M=0 -> strict
    sendHw(16'h0400, "R3");   // short, M=0 stays strict
    sendHw(16'h0001, "R3");
    sendHw(16'h8000, "R5");
    sendHw(16'h2000, "R5");   // one-shot word split by idle cycles
    idle(3);
    sendHw(16'h0002, "R5");
    sendHw(16'h0100, "R4");
    // wrap of the offset
    for (int i = 0; i < 32770; i++) sendHw(16'h0400, "R10");
    idle(4);
    chk("R10", "queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule